// File: doc/BRIEF.md
# Packed Vector Lane Shifter

This block shifts a 128-bit packed operand lane by lane in one registered stage. The operand is split into eight 16-bit lanes, four 32-bit lanes or two 64-bit lanes. Every lane moves by the same count. No bit ever leaves its own lane. Three operations are available: logical left, logical right, and arithmetic right. Arithmetic right is defined only for 16- and 32-bit lanes.

The count comes from one of two sources, chosen by a select input. The first is an 8-bit immediate. The second is a 64-bit count operand. Both sources go through the same range rules:

- A count of at least the lane width clears the lanes for a logical shift.
- For an arithmetic shift, such a count fills each lane with its own sign bit.
- The count is never reduced modulo the width.

A combination that is not supported passes the operand through unchanged and raises an illegal flag. The unsupported combinations are an unknown operation code, the reserved lane code, and arithmetic right on 64-bit lanes.

Top module: `vec_lane_shifter`

## Requirements
- R1: A request accepted with `in_valid` high at a rising clock edge produces `out_valid` high together with its result after that edge. `out_valid` is low after any edge at which `in_valid` was low.
- R2: `lane_sel` encodes the lane width as 0 = 16 bits, 1 = 32 bits, 2 = 64 bits. Lane 0 sits in bits [W-1:0], and no bit crosses a lane boundary.
- R3: `op_sel` encodes the operation as 2 = logical right, 4 = arithmetic right, 6 = logical left.
- R4: For a count below the lane width, each lane is shifted by the count. Logical shifts fill with zeros and arithmetic right fills with the lane's sign bit.
- R5: For a logical shift with a count of at least the lane width, every lane of the result is zero. The threshold is 16 for 16-bit lanes in both directions.
- R6: For an arithmetic right shift with a count of at least the lane width, every lane becomes copies of its own sign bit.
- R7: With `imm_sel` low, the count is the full 64-bit `cnt_reg`, compared unsigned. Any set bit above bit 7 makes the count out of range.
- R8: With `imm_sel` high, the count is the 8-bit unsigned `cnt_imm`, under the same range rules, and `cnt_reg` has no effect on the result.
- R9: An `op_sel` other than 2, 4 or 6, a `lane_sel` of 3, or arithmetic right with `lane_sel` = 2 gives `illegal` = 1 and `vec_out` equal to `vec_in`. Every legal request gives `illegal` = 0.
- R10: While `rst_n` is low, `out_valid`, `illegal` and `vec_out` are all zero.
- R11: A count of zero returns the operand unchanged for every legal operation and width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| vec_in | input | 128 | Packed operand |
| cnt_reg | input | 64 | Count operand (register source) |
| cnt_imm | input | 8 | Immediate count |
| imm_sel | input | 1 | 1 selects the immediate count |
| lane_sel | input | 2 | Lane width code |
| op_sel | input | 3 | Operation code |
| out_valid | output | 1 | Result strobe |
| vec_out | output | 128 | Shifted operand |
| illegal | output | 1 | Unsupported combination flag |

## Verification
The bench probes several boundary cases, each aimed at a specific mistake:

- A count exactly equal to the lane width, and one below it. A design that wraps the count modulo the width would return a shifted copy instead of zeros or sign fill.
- A 16-bit left shift by 16. This catches a threshold taken from the wrong width.
- Register counts of 256 and 2^63. These reveal a range test made only on the low byte.
- An immediate count with a large, conflicting register count. This reveals a wrong source select.
- Negative and positive lanes side by side under arithmetic shifts. This exposes zero fill in place of sign fill, or sign taken from the wrong lane.
- Unsupported encodings. A design that mishandles them would either shift the operand or fail to raise the flag.

// File: rtl/vls_pkg.sv
package vls_pkg;
   typedef enum logic [1:0] {
      LANE_16  = 2'd0,
      LANE_32  = 2'd1,
      LANE_64  = 2'd2,
      LANE_BAD = 2'd3
   } lane_e;

   typedef enum logic [2:0] {
      OP_NONE = 3'd0,
      OP_SRL  = 3'd2,
      OP_SRA  = 3'd4,
      OP_SLL  = 3'd6
   } op_e;

   localparam int NUM_WIDTHS = 3;
   localparam int MIN_LANE_W = 16;
endpackage

// File: rtl/vls_op_decode.sv
module vls_op_decode (
   input  logic [1:0]     lane_sel,
   input  logic [2:0]     op_sel,
   output vls_pkg::op_e   op,
   output logic           bad
);
   import vls_pkg::*;

   always_comb begin
      op  = OP_NONE;
      bad = 1'b0;
      case (op_sel)
         3'd2:    op = OP_SRL;
         3'd4:    op = OP_SRA;
         3'd6:    op = OP_SLL;
         default: bad = 1'b1;
      endcase
      if (lane_sel == LANE_BAD) bad = 1'b1;
      if (op == OP_SRA && lane_sel == LANE_64) bad = 1'b1;
   end
endmodule

// File: rtl/vls_count_sel.sv
module vls_count_sel #(
   parameter int CNT_W = 64,
   parameter int IMM_W = 8
) (
   input  logic             imm_sel,
   input  logic [CNT_W-1:0] cnt_reg,
   input  logic [IMM_W-1:0] cnt_imm,
   output logic [CNT_W-1:0] cnt_eff
);
   localparam int PAD_W = CNT_W - IMM_W;

   always_comb begin
      if (imm_sel) cnt_eff = {{PAD_W{1'b0}}, cnt_imm};
      else         cnt_eff = cnt_reg;
   end
endmodule

// File: rtl/vls_lane_unit.sv
module vls_lane_unit #(
   parameter int LW    = 16,
   parameter int CNT_W = 64
) (
   input  logic [LW-1:0]    lane_in,
   input  logic [CNT_W-1:0] cnt,
   input  vls_pkg::op_e     op,
   output logic [LW-1:0]    lane_out
);
   import vls_pkg::*;
   localparam int SW = $clog2(LW);

   logic          over;
   logic [SW-1:0] sh;
   logic [SW-1:0] sh_ar;

   assign over  = (cnt >= CNT_W'(LW));
   assign sh    = cnt[SW-1:0];
   assign sh_ar = over ? SW'(LW - 1) : sh;

   always_comb begin
      case (op)
         OP_SLL:  lane_out = over ? '0 : (lane_in << sh);
         OP_SRL:  lane_out = over ? '0 : (lane_in >> sh);
         OP_SRA:  lane_out = LW'($signed(lane_in) >>> sh_ar);
         default: lane_out = lane_in;
      endcase
   end
endmodule

// File: rtl/vec_lane_shifter.sv
module vec_lane_shifter #(
   parameter int DATA_W = 128,
   parameter int CNT_W  = 64,
   parameter int IMM_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] vec_in,
   input  logic [CNT_W-1:0]  cnt_reg,
   input  logic [IMM_W-1:0]  cnt_imm,
   input  logic              imm_sel,
   input  logic [1:0]        lane_sel,
   input  logic [2:0]        op_sel,
   output logic              out_valid,
   output logic [DATA_W-1:0] vec_out,
   output logic              illegal
);
   import vls_pkg::*;

   localparam int MAX_LANE_W = MIN_LANE_W << (NUM_WIDTHS - 1);

   if (DATA_W % MAX_LANE_W != 0) begin : g_bad_data_w
      $error("DATA_W must be a multiple of the widest lane");
   end
   if (CNT_W < IMM_W) begin : g_bad_cnt_w
      $error("CNT_W must be at least IMM_W");
   end

   op_e              op;
   logic             bad;
   logic [CNT_W-1:0] cnt_eff;
   logic [DATA_W-1:0] res [NUM_WIDTHS];
   logic [DATA_W-1:0] sel_res;

   vls_op_decode u_dec (
      .lane_sel (lane_sel),
      .op_sel   (op_sel),
      .op       (op),
      .bad      (bad)
   );

   vls_count_sel #(.CNT_W(CNT_W), .IMM_W(IMM_W)) u_cnt (
      .imm_sel (imm_sel),
      .cnt_reg (cnt_reg),
      .cnt_imm (cnt_imm),
      .cnt_eff (cnt_eff)
   );

   for (genvar gw = 0; gw < NUM_WIDTHS; gw++) begin : g_width
      localparam int LW = MIN_LANE_W << gw;
      localparam int NL = DATA_W / LW;
      for (genvar gl = 0; gl < NL; gl++) begin : g_lane
         vls_lane_unit #(.LW(LW), .CNT_W(CNT_W)) u_lane (
            .lane_in  (vec_in[gl*LW +: LW]),
            .cnt      (cnt_eff),
            .op       (op),
            .lane_out (res[gw][gl*LW +: LW])
         );
      end
   end

   always_comb begin
      sel_res = vec_in;
      if (!bad) begin
         case (lane_sel)
            LANE_16: sel_res = res[0];
            LANE_32: sel_res = res[1];
            LANE_64: sel_res = res[2];
            default: sel_res = vec_in;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         vec_out   <= '0;
         illegal   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            vec_out <= sel_res;
            illegal <= bad;
         end
      end
   end
endmodule

// File: rtl/vls_checker.sv
module vls_checker #(
   parameter int DATA_W = 128,
   parameter int CNT_W  = 64,
   parameter int IMM_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] vec_in,
   input logic [CNT_W-1:0]  cnt_reg,
   input logic [IMM_W-1:0]  cnt_imm,
   input logic              imm_sel,
   input logic [1:0]        lane_sel,
   input logic [2:0]        op_sel,
   input logic              out_valid,
   input logic [DATA_W-1:0] vec_out,
   input logic              illegal
);
   logic [CNT_W-1:0] ck;
   logic [CNT_W-1:0] wid;
   logic             logic_op;
   logic             legal_req;

   assign ck        = imm_sel ? CNT_W'(cnt_imm) : cnt_reg;
   assign wid       = CNT_W'(16) << lane_sel;
   assign logic_op  = (op_sel == 3'd2) || (op_sel == 3'd6);
   assign legal_req = (lane_sel != 2'd3) &&
                      ((op_sel == 3'd2) || (op_sel == 3'd6) ||
                       (op_sel == 3'd4 && lane_sel != 2'd2));

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R10: assert (!out_valid && !illegal && vec_out == '0);
      end
   end

   assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));

   assert_illegal_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !legal_req) |=> (illegal && vec_out == $past(vec_in)));

   assert_legal_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && legal_req) |=> !illegal);

   assert_logic_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && legal_req && logic_op && ck >= wid) |=> (vec_out == '0));

   assert_sign_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 3'd4 && lane_sel == 2'd1 && ck >= wid) |=>
      (vec_out[31:0] == {32{$past(vec_in[31])}} &&
       vec_out[DATA_W-1 -: 32] == {32{$past(vec_in[DATA_W-1])}}));

   assert_zero_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && legal_req && ck == '0) |=> (vec_out == $past(vec_in)));
endmodule

bind vec_lane_shifter vls_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W), .IMM_W(IMM_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .vec_in    (vec_in),
   .cnt_reg   (cnt_reg),
   .cnt_imm   (cnt_imm),
   .imm_sel   (imm_sel),
   .lane_sel  (lane_sel),
   .op_sel    (op_sel),
   .out_valid (out_valid),
   .vec_out   (vec_out),
   .illegal   (illegal)
);

// File: tb/vec_lane_shifter_tb.sv
`timescale 1ns/1ps
module vec_lane_shifter_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [127:0] vec_in = '0;
   logic [63:0]  cnt_reg = '0;
   logic [7:0]   cnt_imm = '0;
   logic         imm_sel = 1'b0;
   logic [1:0]   lane_sel = '0;
   logic [2:0]   op_sel = '0;
   logic         out_valid;
   logic [127:0] vec_out;
   logic         illegal;

   int  total = 0;
   int  bad = 0;
   bit  done = 0;

   typedef struct {
      logic [127:0] vec;
      logic         ill;
      string        tag;
   } exp_t;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   vec_lane_shifter u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vec_in(vec_in),
      .cnt_reg(cnt_reg), .cnt_imm(cnt_imm), .imm_sel(imm_sel),
      .lane_sel(lane_sel), .op_sel(op_sel), .out_valid(out_valid),
      .vec_out(vec_out), .illegal(illegal)
   );

   function automatic void model(input logic [127:0] v, input logic [63:0] c,
                                 input int lc, input int op,
                                 output logic [127:0] r, output logic ill);
      int w;
      int amt;
      bit over;
      w   = 16 << lc;
      ill = (lc == 3) || !(op == 2 || op == 4 || op == 6) || (op == 4 && lc == 2);
      if (ill) begin
         r = v;
         return;
      end
      over = (c >= 64'(w));
      amt  = over ? w : int'(c[7:0]);
      for (int b = 0; b < 128; b++) begin
         int p;
         int base;
         p    = b % w;
         base = b - p;
         if (op == 6)      r[b] = (!over && p >= amt) ? v[base + p - amt] : 1'b0;
         else if (op == 2) r[b] = (!over && p + amt < w) ? v[base + p + amt] : 1'b0;
         else begin
            int a2;
            a2   = over ? w - 1 : amt;
            r[b] = (p + a2 < w) ? v[base + p + a2] : v[base + w - 1];
         end
      end
   endfunction

   task automatic send(input logic [127:0] v, input logic [63:0] creg,
                       input logic [7:0] cimm, input logic use_imm,
                       input int lc, input int op, input string tag);
      exp_t e;
      logic [63:0] c;
      @(posedge clk); #1;
      in_valid = 1'b1;
      vec_in   = v;
      cnt_reg  = creg;
      cnt_imm  = cimm;
      imm_sel  = use_imm;
      lane_sel = 2'(lc);
      op_sel   = 3'(op);
      c = use_imm ? {56'd0, cimm} : creg;
      model(v, c, lc, op, e.vec, e.ill);
      e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle();
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         total++;
         if (sb.size() == 0) begin
            bad++;
            $display("FAIL R1: unexpected result act=%h exp=none", vec_out);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (vec_out !== e.vec || illegal !== e.ill) begin
               bad++;
               $display("FAIL %s: act=%h/%b exp=%h/%b", e.tag, vec_out, illegal, e.vec, e.ill);
            end
         end
      end
   end

   localparam logic [127:0] PAT_A = 128'h8001_7FFE_F00F_0FF0_8000_0001_C3A5_5A3C;
   localparam logic [127:0] PAT_B = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_FEDC_BA98;
   localparam logic [127:0] PAT_C = 128'h8000_0000_7FFF_FFFF_FFFF_FFFF_0000_0001;

   initial begin
      repeat (3) @(negedge clk);
      total++;
      if (out_valid !== 1'b0 || illegal !== 1'b0 || vec_out !== '0) begin
         bad++;
         $display("FAIL R10: act=%b/%b/%h exp=0/0/0", out_valid, illegal, vec_out);
      end
      @(posedge clk); #1 rst_n = 1'b1;

      // R1 latency: single request, then strobe must drop
      send(PAT_A, 64'd3, 8'd0, 1'b0, 0, 6, "R1 R4 sll16 by 3");
      idle();
      @(negedge clk); @(negedge clk);
      total++;
      if (out_valid !== 1'b0) begin
         bad++;
         $display("FAIL R1: out_valid act=%b exp=0", out_valid);
      end

      // R2 R3 R4 in-range shifts across widths and operations
      send(PAT_A, 64'd5,  8'd0, 1'b0, 0, 2, "R2 R3 R4 srl16");
      send(PAT_A, 64'd5,  8'd0, 1'b0, 0, 4, "R4 sra16");
      send(PAT_B, 64'd7,  8'd0, 1'b0, 1, 6, "R2 R4 sll32");
      send(PAT_B, 64'd31, 8'd0, 1'b0, 1, 2, "R4 srl32 by w-1");
      send(PAT_C, 64'd9,  8'd0, 1'b0, 1, 4, "R4 sra32");
      send(PAT_B, 64'd63, 8'd0, 1'b0, 2, 6, "R2 R4 sll64 by w-1");
      send(PAT_B, 64'd12, 8'd0, 1'b0, 2, 2, "R4 srl64");
      send(PAT_A, 64'd15, 8'd0, 1'b0, 0, 4, "R4 sra16 by w-1");
      // R5 out-of-range logical
      send(PAT_A, 64'd16, 8'd0, 1'b0, 0, 6, "R5 sll16 by 16");
      send(PAT_A, 64'd16, 8'd0, 1'b0, 0, 2, "R5 srl16 by 16");
      send(PAT_B, 64'd32, 8'd0, 1'b0, 1, 6, "R5 sll32 by 32");
      send(PAT_B, 64'd64, 8'd0, 1'b0, 2, 2, "R5 srl64 by 64");
      // R6 out-of-range arithmetic
      send(PAT_A, 64'd16, 8'd0, 1'b0, 0, 4, "R6 sra16 by 16");
      send(PAT_C, 64'd200, 8'd0, 1'b0, 1, 4, "R6 sra32 by 200");
      // R7 wide register counts
      send(PAT_B, 64'h100, 8'd0, 1'b0, 2, 6, "R7 count 256");
      send(PAT_C, 64'h8000_0000_0000_0001, 8'd0, 1'b0, 1, 4, "R7 count 2^63+1 sra");
      send(PAT_A, 64'h1_0000_0002, 8'd0, 1'b0, 0, 2, "R7 high bit srl");
      // R8 immediate source, register count conflicting
      send(PAT_A, 64'h100, 8'd4, 1'b1, 0, 6, "R8 imm sll16 by 4");
      send(PAT_C, 64'd1,   8'd255, 1'b1, 1, 4, "R8 imm sra32 by 255");
      send(PAT_B, 64'd0,   8'd64, 1'b1, 2, 2, "R8 imm srl64 by 64");
      send(PAT_B, 64'd40,  8'd1, 1'b1, 2, 6, "R8 imm sll64 by 1");
      // R9 illegal combinations
      send(PAT_B, 64'd3, 8'd0, 1'b0, 2, 4, "R9 sra64");
      send(PAT_B, 64'd3, 8'd0, 1'b0, 3, 6, "R9 lane code 3");
      send(PAT_A, 64'd3, 8'd0, 1'b0, 0, 5, "R9 op 5");
      send(PAT_A, 64'd3, 8'd3, 1'b1, 1, 0, "R9 op 0");
      // R11 zero count
      send(PAT_A, 64'd0, 8'd0, 1'b0, 0, 4, "R11 sra16 by 0");
      send(PAT_B, 64'd0, 8'd0, 1'b0, 2, 6, "R11 sll64 by 0");
      send(PAT_C, 64'd77, 8'd0, 1'b1, 1, 2, "R11 R8 imm zero srl32");
      idle();
      repeat (4) @(negedge clk);

      total++;
      if (sb.size() != 0) begin
         bad++;
         $display("FAIL R1: pending results act=%0d exp=0", sb.size());
      end
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R1: watchdog expired act=hung exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule